// File: doc/BRIEF.md
# Barrett Carryless Multiply-Modulo-Polynomial Unit

This unit multiplies two 16-bit polynomials over GF(2) and reduces the product modulo the fixed degree-16 generator 0x11021 (x^16 + x^12 + x^5 + 1). It is the core step needed to advance a 16-bit CRC remainder past a run of zero bits, or to weight a CRC term by a power of x, in a single evaluation instead of a bit-serial loop.

Reduction does not use a 16-step shift-and-XOR sequence. It uses a Barrett-style quotient estimate. The upper half of the 31-bit carryless product is multiplied by a reciprocal constant. The reciprocal is the floor of x^31 divided by the generator, and it is computed at elaboration time. That product is shifted to form the quotient. The quotient times the generator is then XORed into the lower half of the product. An optional output register, selected by a parameter, retimes the result and carries a valid flag alongside it.

Top module: `gf2_mulmod`

## Requirements
- R1: For every operand pair, `result` equals (op_a · op_b) mod 0x11021, where multiplication is carryless and addition is XOR.
- R2: When the exponents of single-bit operands sum to less than 16, the result is the unreduced single-bit product, so x^i · x^j = x^(i+j).
- R3: The reduction folds x^16 back onto the generator's low part, so 0x8000 · 0x0002 gives 0x1021.
- R4: If either operand is zero, the result is zero.
- R5: If op_a is 0x0001, the result equals op_b unchanged.
- R6: The operation is commutative: swapping op_a and op_b gives the same result.
- R7: With the default registered variant, `out_valid` is `in_valid` delayed by one clock. The result for operands presented with `in_valid` high appears in that same later cycle.
- R8: While `in_valid` is low, `result` keeps its last value, whatever the operand inputs do.
- R9: While `rst_n` is low, `out_valid` is 0.
- R10: For all-ones operands (0xFFFF · 0xFFFF), the result matches the bit-serial reference. This case exercises every partial product and the deepest reduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the valid flag |
| in_valid | input | 1 | Operands on op_a/op_b are to be processed |
| op_a | input | 16 | First polynomial operand, bit i is the coefficient of x^i |
| op_b | input | 16 | Second polynomial operand |
| out_valid | output | 1 | result carries a fresh product |
| result | output | 16 | (op_a · op_b) mod 0x11021 |

## Verification
The hardest situation to reach is a product whose upper half makes every bit of the quotient estimate matter. Only then is an off-by-one in a shift amount or in the reciprocal exposed. Dense operands such as all-ones and 0x8000 with high-weight partners reach it directly. Long runs of random pairs, each compared against a bit-serial model on every clock, cover the rest. Idle cycles with changing operand inputs are mixed in so that the hold behaviour of the output register is observed between products.

// File: rtl/gf2_pkg.sv
package gf2_pkg;

  // Floor of x^(2w-1) divided by the polynomial poly (degree w), over GF(2).
  // Used as the reciprocal for the Barrett quotient estimate.
  function automatic logic [63:0] gf2_recip(input logic [64:0] poly, input int w);
    logic [127:0] num;
    logic [63:0]  quo;
    num = '0;
    quo = '0;
    num[2*w-1] = 1'b1;
    for (int i = 127; i >= 0; i--) begin
      if (i >= w && i <= 2*w-1 && num[i]) begin
        quo[i-w] = 1'b1;
        num = num ^ ({63'b0, poly} << (i - w));
      end
    end
    return quo;
  endfunction

endpackage

// File: rtl/gf2_clmul.sv
// Carryless multiplier: every product bit is the XOR of the AND terms whose
// indices sum to its position. The low SKIP bits are not produced.
module gf2_clmul #(
  parameter int AW   = 16,
  parameter int BW   = 16,
  parameter int SKIP = 0,
  localparam int PW  = AW + BW - 1,
  localparam int OW  = PW - SKIP
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [OW-1:0] p
);

  for (genvar k = SKIP; k < PW; k++) begin : g_bit
    logic [AW-1:0] terms;
    always_comb begin
      terms = '0;
      for (int i = 0; i < AW; i++) begin
        if (k - i >= 0 && k - i < BW) terms[i] = a[i] & b[k-i];
      end
    end
    // Reduction XOR maps to a balanced tree: depth ceil(log2(AW)).
    assign p[k-SKIP] = ^terms;
  end

endmodule

// File: rtl/gf2_barrett_reduce.sv
// Reduces a (2W-1)-bit carryless product modulo POLY using a reciprocal
// quotient estimate and one correction multiply.
module gf2_barrett_reduce #(
  parameter int          W    = 16,
  parameter logic [W:0]  POLY = 17'h11021,
  localparam int         PW   = 2*W - 1
) (
  input  logic [PW-1:0] prod,
  output logic [W-1:0]  rem
);
  import gf2_pkg::*;

  localparam logic [W-1:0] RECIP = W'(gf2_recip(65'(POLY), W));

  logic [W-2:0]  hi;
  logic [W-2:0]  quo;
  logic [PW-1:0] qp;

  assign hi = prod[PW-1:W];

  // quotient = (hi * RECIP) >> (W-1); low W-1 bits never built
  gf2_clmul #(.AW(W-1), .BW(W), .SKIP(W-1)) u_quo (
    .a (hi),
    .b (RECIP),
    .p (quo)
  );

  gf2_clmul #(.AW(W-1), .BW(W+1), .SKIP(0)) u_corr (
    .a (quo),
    .b (POLY),
    .p (qp)
  );

  assign rem = prod[W-1:0] ^ qp[W-1:0];

  // The estimated quotient must cancel the whole upper half of the product.
  always_comb begin
    if (!$isunknown(prod))
      AST_QUOTIENT_EXACT: assert (qp[PW-1:W] == prod[PW-1:W]); // R1
  end

endmodule

// File: rtl/gf2_mulmod.sv
module gf2_mulmod #(
  parameter int          W    = 16,
  parameter logic [W:0]  POLY = 17'h11021,
  parameter bit          PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] result
);

  localparam int PW = 2*W - 1;

  logic [PW-1:0] prod;
  logic [W-1:0]  rem;

  gf2_clmul #(.AW(W), .BW(W), .SKIP(0)) u_mul (
    .a (op_a),
    .b (op_b),
    .p (prod)
  );

  gf2_barrett_reduce #(.W(W), .POLY(POLY)) u_red (
    .prod (prod),
    .rem  (rem)
  );

  if (PIPE) begin : g_reg
    logic         vld_d, vld_q;
    logic [W-1:0] res_q;

    always_comb vld_d = in_valid;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (in_valid) res_q <= rem;
    end

    assign out_valid = vld_q;
    assign result    = res_q;

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R7
    AST_IDLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R7
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_a == '0 || op_b == '0)) |=> (result == '0)); // R4
    AST_UNIT_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_a == W'(1)) |=> (result == $past(op_b))); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && out_valid) |=> $stable(result)); // R8
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = rem;
  end

endmodule

// File: tb/gf2_mulmod_bench.sv
module gf2_mulmod_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] op_a, op_b;
  logic        out_valid;
  logic [15:0] result;

  int n_run  = 0;
  int n_fail = 0;
  logic [15:0] held;
  bit          have_held = 0;
  logic [15:0] prev_res;

  always #(CLK_P/2) clk = ~clk;

  gf2_mulmod u_gf2_mulmod (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
  );

  // Bit-serial multiply-mod reference: Horner over b, MSB first.
  function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] acc;
    acc = '0;
    for (int i = 15; i >= 0; i--) begin
      acc = acc[15] ? ((acc << 1) ^ 16'h1021) : (acc << 1);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, compare one clock later at the next falling edge.
  task automatic drive(input logic v, input logic [15:0] a, input logic [15:0] b, input string tag);
    logic [15:0] exp;
    in_valid = v; op_a = a; op_b = b;
    @(negedge clk);
    check(out_valid == v, "R7 out_valid", 16'(out_valid), 16'(v));
    if (v) begin
      exp = ref_mul(a, b);
      check(result == exp, tag, result, exp);
      held = exp; have_held = 1;
    end else if (have_held) begin
      check(result == held, "R8 hold while idle", result, held);
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset out_valid", 16'(out_valid), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: small exponents, no reduction
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        drive(1'b1, 16'(1) << i, 16'(1) << j, "R2 monomial");
        check(result == (16'(1) << (i + j)), "R2 unreduced", result, 16'(1) << (i + j));
      end
    end

    // R3: x^15 * x = x^16 -> 0x1021
    drive(1'b1, 16'h8000, 16'h0002, "R3 fold");
    check(result == 16'h1021, "R3 x^16", result, 16'h1021);

    // R4: zero operands
    drive(1'b1, 16'h0000, 16'hBEEF, "R4 zero a");
    check(result == 16'h0, "R4 zero a", result, 16'h0);
    drive(1'b1, 16'hFFFF, 16'h0000, "R4 zero b");
    check(result == 16'h0, "R4 zero b", result, 16'h0);

    // R5: identity
    drive(1'b1, 16'h0001, 16'hA5C3, "R5 unit");
    check(result == 16'hA5C3, "R5 unit", result, 16'hA5C3);
    drive(1'b1, 16'h0001, 16'hFFFF, "R5 unit ones");
    check(result == 16'hFFFF, "R5 unit ones", result, 16'hFFFF);

    // R10 corner operands
    drive(1'b1, 16'hFFFF, 16'hFFFF, "R10 all ones");
    drive(1'b1, 16'h8000, 16'h8000, "R10 top bits");
    drive(1'b1, 16'h8000, 16'hFFFF, "R10 top by ones");

    // R8: idle with changing operands
    drive(1'b0, 16'h1234, 16'h5678, "R8 idle");
    drive(1'b0, 16'hFFFF, 16'h0001, "R8 idle");

    // R1 random, with R6 commutativity and interleaved idles
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      drive(1'b1, a, b, "R1 random");
      prev_res = result;
      drive(1'b1, b, a, "R1 swapped");
      check(result == prev_res, "R6 commutative", result, prev_res);
      if (n % 7 == 3) drive(1'b0, ~a, ~b, "R8 idle");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule